// File: doc/BRIEF.md
# Virtually indexed, physically tagged cache tag lookup

This block holds the tag directory of a set-associative cache whose set is chosen from the virtual address while the stored tag comes from the physical address. A request presents a virtual address. The set index is latched from it at once. One cycle later the translated physical address arrives together with a translation-valid flag. The tags of every way in the latched set are compared against the physical tag, and a registered result follows one cycle after that. The result is a hit flag, a one-hot hit way, a one-hot allocated way on a miss, and the page colour of the access.

The colour is the group of index bits that sit above the page offset. Two virtual aliases of one physical page agree on every index bit inside the page but may disagree on the colour bits. Software that maps shared pages uses the reported colour to keep aliases in the same set. On a miss with a valid translation, the way named by a per-set round-robin pointer receives the physical tag and is marked valid. An invalidate-all command sweeps the directory one set per cycle while a busy flag is raised. The data array, refill, writeback, translation and coherency are handled elsewhere.

Top module: `vipt_tag_lookup`

## Requirements
- R1: With default parameters (32 KB, 4 ways, 32-byte lines), the set index is virtual-address bits 12..5, giving 256 sets, and the stored and compared tag is physical-address bits 31..13.
- R2: A request is accepted in cycle 0 when req_valid_i is 1, busy_o is 0 and inval_i is 0. The physical address is sampled in cycle 1. rsp_valid_o, hit_o, hit_way_o, alloc_way_o and colour_o are valid for exactly one cycle in cycle 2. While rsp_valid_o is 0, hit_o, hit_way_o and alloc_way_o are 0.
- R3: hit_o is 1 when a valid way of the indexed set holds the physical tag. hit_way_o then has only bit w set, where w is that way. On a miss hit_way_o is 0.
- R4: On a miss with a valid translation, alloc_way_o has only bit p set, where p is the round-robin pointer of the set. The pointer starts at way 0 and advances by one modulo 4 per allocation in that set. The tag is written to way p and marked valid, so a later lookup of it hits in way p. On a hit, alloc_way_o is 0.
- R5: If pa_valid_i is 0 in cycle 1, then hit_o, hit_way_o and alloc_way_o are 0 in cycle 2, and neither the directory nor the pointer changes.
- R6: colour_o equals the virtual-address bits from 12 up to the lowest tag bit minus one. With default parameters that is bit 12 alone.
- R7: When one physical page is reached through two virtual addresses, a same-colour alias hits the line that the first address allocated. An alias of different colour misses and allocates in the set that differs in the colour bit. No two ways of one set ever hold the same valid tag.
- R8: When inval_i is 1 while busy_o is 0, busy_o is 1 from the next cycle for exactly one cycle per set (256 by default). After that, every lookup misses and every round-robin pointer is back at way 0.
- R9: A request presented while busy_o or inval_i is 1 is dropped, and no response appears for it.
- R10: After reset, busy_o and rsp_valid_o are 0 and every entry is invalid.
- R11: With CACHE_BYTES set to 65536, the index is virtual-address bits 13..5 (512 sets), the tag is physical-address bits 31..14, and colour_o is virtual-address bits 13..12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request, cycle 0 |
| req_vaddr_i | input | ADDR_W | Virtual address of the request |
| pa_valid_i | input | 1 | Translation valid, cycle 1 |
| pa_addr_i | input | ADDR_W | Translated physical address, cycle 1 |
| inval_i | input | 1 | Start invalidation of all entries |
| busy_o | output | 1 | Invalidation sweep in progress |
| rsp_valid_o | output | 1 | Lookup result valid, cycle 2 |
| hit_o | output | 1 | Tag matched a valid way |
| hit_way_o | output | N_WAYS | One-hot matching way |
| alloc_way_o | output | N_WAYS | One-hot way allocated on a miss |
| colour_o | output | COL_W | Page colour of the request |

## Verification
Each lookup result is registered. The result of a request driven in cycle 0, with its translation in cycle 1, is read one falling edge after the second rising edge. The bench drives on falling edges and samples the result at that same point. The invalidate sweep is measured by sampling busy_o on every falling edge after the command until it drops. That gives the length directly in cycles. Requests dropped during the sweep are confirmed by watching rsp_valid_o on the falling edges that would carry their results.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } inval_st_e;
endpackage

// File: rtl/vipt_inval_seq.sv
module vipt_inval_seq #(
  parameter int N_SETS = 256,
  localparam int IDX_W = $clog2(N_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  import vipt_pkg::*;

  inval_st_e        st_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SWEEP;
          idx_q <= '0;
        end
        ST_SWEEP: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(N_SETS - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q == ST_SWEEP);
  assign clr_idx_o = idx_q;
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int N_SETS = 256,
  parameter int N_WAYS = 4,
  parameter int TAG_W  = 19,
  localparam int IDX_W = $clog2(N_SETS),
  localparam int WAY_W = $clog2(N_WAYS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [IDX_W-1:0]               idx_i,
  output logic [N_WAYS-1:0][TAG_W-1:0]   rd_tags_o,
  output logic [N_WAYS-1:0]              rd_valid_o,
  output logic [WAY_W-1:0]               rd_ptr_o,
  input  logic                           wr_en_i,
  input  logic [WAY_W-1:0]               wr_way_i,
  input  logic [TAG_W-1:0]               wr_tag_i,
  input  logic                           clr_en_i,
  input  logic [IDX_W-1:0]               clr_idx_i
);
  logic [N_WAYS-1:0]             valid_q [N_SETS];
  logic [WAY_W-1:0]              ptr_q   [N_SETS];
  logic [N_WAYS-1:0][TAG_W-1:0]  tag_q   [N_SETS];

  // valid bits and victim pointers; a sweep clear wins over a write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (wr_en_i) begin
        valid_q[idx_i][wr_way_i] <= 1'b1;
        ptr_q[idx_i]             <= wr_way_i + WAY_W'(1);
      end
      if (clr_en_i) begin
        valid_q[clr_idx_i] <= '0;
        ptr_q[clr_idx_i]   <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[idx_i][wr_way_i] <= wr_tag_i;
  end

  assign rd_tags_o  = tag_q[idx_i];
  assign rd_valid_o = valid_q[idx_i];
  assign rd_ptr_o   = ptr_q[idx_i];
endmodule

// File: rtl/vipt_way_cmp.sv
module vipt_way_cmp #(
  parameter int N_WAYS = 4,
  parameter int TAG_W  = 19
) (
  input  logic [N_WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [N_WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]             tag_i,
  output logic [N_WAYS-1:0]            hit_vec_o
);
  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 32768,
  parameter int N_WAYS      = 4,
  parameter int LINE_BYTES  = 32,
  parameter int PAGE_BYTES  = 4096,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int N_SETS  = CACHE_BYTES / (N_WAYS * LINE_BYTES),
  localparam int IDX_W   = $clog2(N_SETS),
  localparam int TAG_LSB = OFF_W + IDX_W,
  localparam int TAG_W   = ADDR_W - TAG_LSB,
  localparam int PAGE_W  = $clog2(PAGE_BYTES),
  localparam int COL_W   = TAG_LSB - PAGE_W,
  localparam int WAY_W   = $clog2(N_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              pa_valid_i,
  input  logic [ADDR_W-1:0] pa_addr_i,
  input  logic              inval_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [N_WAYS-1:0] hit_way_o,
  output logic [N_WAYS-1:0] alloc_way_o,
  output logic [COL_W-1:0]  colour_o
);
  logic                          busy, accept, inval_start;
  logic                          s1_valid_q;
  logic [IDX_W-1:0]              s1_idx_q;
  logic [COL_W-1:0]              s1_col_q;
  logic [N_WAYS-1:0][TAG_W-1:0]  rd_tags;
  logic [N_WAYS-1:0]             rd_valid, hit_vec;
  logic [WAY_W-1:0]              rd_ptr;
  logic [TAG_W-1:0]              pa_tag;
  logic                          lookup_ok, any_hit, do_alloc;
  logic [IDX_W-1:0]              clr_idx;
  logic                          unused_bits;

  assign unused_bits = ^{pa_addr_i[TAG_LSB-1:0], req_vaddr_i[ADDR_W-1:TAG_LSB],
                         req_vaddr_i[OFF_W-1:0]};

  // no request enters while the directory is being swept
  assign accept      = req_valid_i & ~busy & ~inval_i;
  assign inval_start = inval_i & ~busy;

  // stage 0 -> 1: index and colour from the virtual address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_col_q   <= '0;
    end else begin
      s1_valid_q <= accept;
      s1_idx_q   <= req_vaddr_i[TAG_LSB-1:OFF_W];
      s1_col_q   <= req_vaddr_i[TAG_LSB-1:PAGE_W];
    end
  end

  vipt_inval_seq #(.N_SETS(N_SETS)) u_inval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (inval_start),
    .busy_o    (busy),
    .clr_idx_o (clr_idx)
  );

  vipt_tag_store #(.N_SETS(N_SETS), .N_WAYS(N_WAYS), .TAG_W(TAG_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (s1_idx_q),
    .rd_tags_o  (rd_tags),
    .rd_valid_o (rd_valid),
    .rd_ptr_o   (rd_ptr),
    .wr_en_i    (do_alloc),
    .wr_way_i   (rd_ptr),
    .wr_tag_i   (pa_tag),
    .clr_en_i   (busy),
    .clr_idx_i  (clr_idx)
  );

  vipt_way_cmp #(.N_WAYS(N_WAYS), .TAG_W(TAG_W)) u_cmp (
    .tags_i    (rd_tags),
    .valid_i   (rd_valid),
    .tag_i     (pa_tag),
    .hit_vec_o (hit_vec)
  );

  // stage 1: physical tag compare and victim allocation
  assign pa_tag    = pa_addr_i[ADDR_W-1:TAG_LSB];
  assign lookup_ok = s1_valid_q & pa_valid_i;
  assign any_hit   = |hit_vec;
  assign do_alloc  = lookup_ok & ~any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      hit_way_o   <= '0;
      alloc_way_o <= '0;
      colour_o    <= '0;
    end else begin
      rsp_valid_o <= s1_valid_q;
      hit_o       <= lookup_ok & any_hit;
      hit_way_o   <= lookup_ok ? hit_vec : '0;
      alloc_way_o <= do_alloc ? (N_WAYS'(1) << rd_ptr) : '0;
      colour_o    <= s1_col_q;
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/vipt_tag_lookup_chk.sv
module vipt_tag_lookup_chk #(
  parameter int ADDR_W = 32,
  parameter int N_SETS = 256,
  parameter int N_WAYS = 4,
  parameter int PAGE_W = 12,
  parameter int COL_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              pa_valid_i,
  input logic              inval_i,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic [N_WAYS-1:0] hit_way_o,
  input logic [N_WAYS-1:0] alloc_way_o,
  input logic [COL_W-1:0]  colour_o
);
  int unsigned busy_cnt;
  logic        take;

  assign take = req_valid_i && !busy_o && !inval_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ##1 rsp_valid_o);

  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!hit_o && hit_way_o == '0 && alloc_way_o == '0));

  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ##1 !rsp_valid_o);

  p_onehot_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($onehot0(hit_way_o) && (hit_o == (hit_way_o != '0))));

  p_alloc_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !hit_o && $past(pa_valid_i)) |-> ($countones(alloc_way_o) == 1));

  p_no_alloc_on_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o) |-> (alloc_way_o == '0));

  p_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(pa_valid_i)) |-> (!hit_o && alloc_way_o == '0));

  p_colour_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ##1 (colour_o == $past(req_vaddr_i[PAGE_W+COL_W-1:PAGE_W], 2)));

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(inval_i));

  p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < N_SETS));

  logic unused_chk;
  assign unused_chk = ^{req_vaddr_i};
endmodule

bind vipt_tag_lookup vipt_tag_lookup_chk #(
  .ADDR_W (ADDR_W),
  .N_SETS (N_SETS),
  .N_WAYS (N_WAYS),
  .PAGE_W (PAGE_W),
  .COL_W  (COL_W)
) i_chk (.*);

// File: tb/test_vipt_tag_lookup.sv
module test_vipt_tag_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, pa_valid = 1'b0, inval = 1'b0;
  logic [31:0] va = '0, pa = '0;

  logic       busy_s, rv_s, hit_s;
  logic [3:0] hw_s, aw_s;
  logic [0:0] col_s;
  logic       busy_b, rv_b, hit_b;
  logic [3:0] hw_b, aw_b;
  logic [1:0] col_b;

  vipt_tag_lookup i_vipt_tag_lookup (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(va),
    .pa_valid_i(pa_valid), .pa_addr_i(pa), .inval_i(inval), .busy_o(busy_s),
    .rsp_valid_o(rv_s), .hit_o(hit_s), .hit_way_o(hw_s), .alloc_way_o(aw_s),
    .colour_o(col_s)
  );

  vipt_tag_lookup #(.CACHE_BYTES(65536)) i_vipt_tag_lookup_big (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(va),
    .pa_valid_i(pa_valid), .pa_addr_i(pa), .inval_i(inval), .busy_o(busy_b),
    .rsp_valid_o(rv_b), .hit_o(hit_b), .hit_way_o(hw_b), .alloc_way_o(aw_b),
    .colour_o(col_b)
  );

  int n_tests = 0, n_fail = 0;

  // reference directory: config 0 = 32 KB, config 1 = 64 KB
  logic [31:0] m_tag [2][512][4];
  bit          m_val [2][512][4];
  int          m_ptr [2][512];
  bit          exp_hit [2];
  int          exp_hv [2], exp_av [2], exp_col [2];

  task automatic model_clear();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 512; s++) begin
        m_ptr[c][s] = 0;
        for (int w = 0; w < 4; w++) m_val[c][s][w] = 0;
      end
  endtask

  task automatic model_step(input logic [31:0] a, input logic [31:0] p, input bit pv);
    for (int c = 0; c < 2; c++) begin
      int          ix;
      logic [31:0] t;
      ix = int'((a >> 5) & (c == 1 ? 32'd511 : 32'd255));
      t  = p >> (c == 1 ? 14 : 13);
      exp_hit[c] = 0;
      exp_hv[c]  = 0;
      exp_av[c]  = 0;
      exp_col[c] = int'((a >> 12) & (c == 1 ? 32'd3 : 32'd1));
      if (pv) begin
        for (int w = 0; w < 4; w++)
          if (m_val[c][ix][w] && m_tag[c][ix][w] == t) begin
            exp_hit[c] = 1;
            exp_hv[c]  = 1 << w;
          end
        if (!exp_hit[c]) begin
          int v;
          v = m_ptr[c][ix];
          exp_av[c] = 1 << v;
          m_val[c][ix][v] = 1;
          m_tag[c][ix][v] = t;
          m_ptr[c][ix] = (v + 1) % 4;
        end
      end
    end
  endtask

  task automatic chk(input string rq, input int c, input logic rv, input logic h,
                     input logic [3:0] hv, input logic [3:0] av, input logic [1:0] col);
    n_tests++;
    if (rv !== 1'b1 || h !== exp_hit[c] || hv !== 4'(exp_hv[c]) ||
        av !== 4'(exp_av[c]) || col !== 2'(exp_col[c])) begin
      n_fail++;
      $display("FAIL %s cfg%0d: rv=%b hit=%b way=%h alloc=%h col=%0d expected rv=1 hit=%0b way=%h alloc=%h col=%0d",
               rq, c, rv, h, hv, av, col, exp_hit[c], 4'(exp_hv[c]), 4'(exp_av[c]), exp_col[c]);
    end
  endtask

  task automatic check_bit(input string rq, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", rq, got, exp);
    end
  endtask

  task automatic check_int(input string rq, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  // request in cycle 0, translation in cycle 1, result read in cycle 2
  task automatic access(input string rq, input logic [31:0] a, input logic [31:0] p, input bit pv);
    @(negedge clk); req_valid = 1'b1; va = a;
    @(negedge clk); req_valid = 1'b0; pa_valid = pv; pa = p;
    @(negedge clk); pa_valid = 1'b0;
    model_step(a, p, pv);
    chk({rq, " R2"}, 0, rv_s, hit_s, hw_s, aw_s, {1'b0, col_s});
    chk({rq, " R11"}, 1, rv_b, hit_b, hw_b, aw_b, col_b);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: run still active after 150000 cycles, expected completion");
    summary();
    $finish;
  end

  initial begin
    int cnt_s, cnt_b;
    bit saw_rv;
    model_clear();
    repeat (3) @(negedge clk);
    check_bit("R10 busy after reset", busy_s | busy_b, 1'b0);
    check_bit("R10 rsp_valid after reset", rv_s | rv_b, 1'b0);
    rst_n = 1'b1;

    // R1 / R10: every line from empty misses, then hits on repeat
    for (int l = 0; l < 512; l++)
      access("R1 R10 R4 fill", 32'(l) << 5, 32'hA000_0000 + (32'(l) << 5), 1'b1);
    for (int l = 0; l < 512; l++)
      access("R3 R1 rehit", 32'(l) << 5, 32'hA000_0000 + (32'(l) << 5), 1'b1);

    // R4: round robin in one set, oldest evicted
    for (int k = 0; k < 6; k++)
      access("R4 rr", 32'h0000_00E0, 32'h4000_0000 + (32'(k) << 16), 1'b1);
    access("R4 evicted", 32'h0000_00E0, 32'h4000_0000, 1'b1);
    access("R3 resident", 32'h0000_00E0, 32'h4005_0000, 1'b1);

    // R5: failed translation leaves directory and pointer untouched
    access("R5 fault", 32'h0000_0300, 32'h5555_0300, 1'b0);
    access("R5 fault repeat", 32'h0000_0300, 32'h5555_0300, 1'b0);
    access("R5 after fault", 32'h0000_0300, 32'h5555_0300, 1'b1);

    // R7 / R6: one physical page through aliases of each colour
    access("R7 first", 32'h0001_0040, 32'h7777_3040, 1'b1);
    access("R7 same colour", 32'h0003_2040, 32'h7777_3040, 1'b1);
    check_bit("R7 same colour hits", hit_s, 1'b1);
    access("R7 other colour", 32'h0001_1040, 32'h7777_3040, 1'b1);
    check_bit("R7 other colour misses", hit_s, 1'b0);
    access("R7 other colour again", 32'h0001_1040, 32'h7777_3040, 1'b1);
    access("R7 first again", 32'h0001_0040, 32'h7777_3040, 1'b1);
    access("R6 colour", 32'h0000_3FE0, 32'h1234_5FE0, 1'b1);

    // R8 / R9: invalidate with a colliding request, then a request mid-sweep
    @(negedge clk); inval = 1'b1; req_valid = 1'b1; va = 32'h40;
    cnt_s = 0; cnt_b = 0; saw_rv = 0;
    for (int k = 1; k <= 700; k++) begin
      @(negedge clk);
      if (busy_s) cnt_s++;
      if (busy_b) cnt_b++;
      if (rv_s || rv_b) saw_rv = 1;
      case (k)
        1: begin inval = 1'b0; req_valid = 1'b0; pa_valid = 1'b1; pa = 32'hA000_0040; end
        2: pa_valid = 1'b0;
        3: begin req_valid = 1'b1; va = 32'h60; end
        4: begin req_valid = 1'b0; pa_valid = 1'b1; pa = 32'hA000_0060; end
        5: pa_valid = 1'b0;
        default: ;
      endcase
      if (k > 6 && !busy_s && !busy_b) break;
    end
    check_int("R8 sweep length 32KB", cnt_s, 256);
    check_int("R8 sweep length 64KB R11", cnt_b, 512);
    check_bit("R9 dropped requests", saw_rv, 1'b0);
    model_clear();

    for (int l = 0; l < 8; l++)
      access("R8 post-invalidate", 32'(l) << 5, 32'hA000_0000 + (32'(l) << 5), 1'b1);
    access("R8 pointer reset", 32'h0000_00E0, 32'h4000_0000, 1'b1);

    summary();
    $finish;
  end
endmodule